// File: doc/BRIEF.md
# Multiplexed BCD Digit Scanner with Transfer Strobes

This block presents a held five-digit BCD result on one shared 4-bit data bus, one digit at a time. A one-hot, active-high digit-drive vector selects which digit the bus carries. A display multiplexer or an external latch can follow it. Each time the conversion sequencer reports a finished result, the scan starts again at the most significant digit. During that first scan the block gives five short active-low strobe pulses, one in the middle of each digit slot, so that a UART, a processor port or a latch can capture the digits. After that first scan the block keeps scanning without strobes until the next result arrives.

When the latched result is flagged as overrange, the data bus reads zero. After the fifth strobe every digit drive goes low. The drives stay low until the sequencer reports the start of its next reference-integrate phase. Scanning then resumes, which makes the display blink.

The control is a three-state machine:
- ST_IDLE: no result has arrived since reset.
- ST_SCAN: the drives and the bus are active.
- ST_BLANK: overrange blanking.

The transitions are:
- any state to ST_SCAN on a result event (`eoc`), which also loads the data and arms the strobes;
- ST_SCAN to ST_BLANK on the fifth strobe when the latched result is overrange;
- ST_BLANK to ST_SCAN on `ref_start`, which restarts at the most significant digit with no strobes.

In all other cases the machine stays in its current state.

Top module: `digit_scanner`

## Requirements
- R1: From reset until the first `eoc`, `digit_drv` is all zero, `bcd` is zero and `strobe_n` stays high.
- R2: `digit_drv` has at most one bit set. Digit i is held on `digits[4*i+3:4*i]` and selected by `digit_drv[i]`, where i=4 is the most significant digit. The scan runs 4, 3, 2, 1, 0 and then wraps back to 4 for as long as the block is scanning.
- R3: The drive for digit 4 stays high for 201 clocks. Each of the other drives stays high for 200 clocks.
- R4: While a drive is high and the result is not overrange, `bcd` equals that digit's latched value. `bcd` changes in the same cycle as the drive.
- R5: `strobe_n` goes low only during the second half of one clock, that is, from the falling edge to the next rising edge. In the slot of digit 4 it goes low in the cycle 101 clocks after the drive rose. In each other slot it goes low 100 clocks after the drive rose.
- R6: Each `eoc` produces exactly five strobe pulses. Later scans of the same result produce none.
- R7: While the latched result is overrange, `bcd` is zero in every cycle.
- R8: For an overrange result, all drives go low from the cycle after the fifth strobe. They stay low until a `ref_start` pulse. The next cycle then starts a scan at digit 4, and that scan has no strobes.
- R9: An `eoc` during a scan restarts the scan at digit 4 in the following cycle, loads the new data and re-arms the five strobes.
- R10: A `ref_start` pulse while the block is scanning (not blanked) has no effect on the drives, the data or the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the strobe also uses its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| eoc | input | 1 | One-cycle pulse: a new result is on `digits`/`ovr` |
| ovr | input | 1 | Overrange flag of the result, sampled with `eoc` |
| digits | input | 20 | Five BCD digits, digit i at bits 4*i+3..4*i, digit 4 most significant |
| ref_start | input | 1 | One-cycle pulse at the start of a reference-integrate phase |
| digit_drv | output | 5 | One-hot digit select, bit 4 is the most significant digit |
| bcd | output | 4 | BCD value of the selected digit, positive true |
| strobe_n | output | 1 | Active-low half-clock transfer strobe |

## Verification
The assertions check the following on every cycle:
- the drive vector is one-hot or empty;
- every change from one active drive to the next follows the 4-to-0 rotation;
- an `eoc` lands on digit 4;
- the bus reads zero whenever no digit is driven or the held result is overrange;
- a strobe appears only while a digit is driven;
- blanking holds until it is released.

Only the bench scenarios can show the slot lengths, where each strobe falls within its slot, and the exact count of five strobes per result with none afterwards. The same holds for the blanking point after the fifth strobe, the restart in the middle of a scan, and the harmless `ref_start` during a scan. The bench compares every cycle against a cycle-position model built from the requirements.

// File: rtl/ds_pkg.sv
`timescale 1ns/1ps
package ds_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_BLANK = 2'd2
    } scan_state_e;
endpackage

// File: rtl/ds_slot_timer.sv
`timescale 1ns/1ps
// Slot counter and digit index; the MSD slot is one clock longer.
module ds_slot_timer #(
    parameter int NUM_DIGITS = 5,
    parameter int SLOT_CLKS  = 200,
    parameter int STB_AT     = 100,
    localparam int IDX_W     = $clog2(NUM_DIGITS),
    localparam int CNT_W     = $clog2(SLOT_CLKS + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             run,
    output logic [IDX_W-1:0] idx,
    output logic             strobe_pt
);
    localparam logic [IDX_W-1:0] MSD_IDX = IDX_W'(NUM_DIGITS - 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] stb_cnt;
    logic             is_msd;
    logic             slot_end;

    always_comb begin
        is_msd    = (idx == MSD_IDX);
        last_cnt  = is_msd ? CNT_W'(SLOT_CLKS) : CNT_W'(SLOT_CLKS - 1);
        stb_cnt   = is_msd ? CNT_W'(STB_AT + 1) : CNT_W'(STB_AT);
        slot_end  = (cnt == last_cnt);
        strobe_pt = (cnt == stb_cnt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            idx <= MSD_IDX;
        end else if (restart) begin
            cnt <= '0;
            idx <= MSD_IDX;
        end else if (run) begin
            if (slot_end) begin
                cnt <= '0;
                idx <= (idx == '0) ? MSD_IDX : idx - 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ds_result_hold.sv
`timescale 1ns/1ps
// Holds the result and overrange flag; selects the active digit onto the bus.
module ds_result_hold #(
    parameter int NUM_DIGITS = 5,
    parameter int BCD_W      = 4,
    localparam int IDX_W     = $clog2(NUM_DIGITS),
    localparam int DATA_W    = NUM_DIGITS * BCD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    input  logic              ovr_in,
    input  logic [IDX_W-1:0]  idx,
    input  logic              drive_on,
    output logic [BCD_W-1:0]  bcd,
    output logic              ovr_q
);
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            ovr_q  <= 1'b0;
        end else if (load) begin
            data_q <= din;
            ovr_q  <= ovr_in;
        end
    end

    always_comb begin
        if (drive_on && !ovr_q) bcd = data_q[idx*BCD_W +: BCD_W];
        else                    bcd = '0;
    end
endmodule

// File: rtl/ds_strobe_gen.sv
`timescale 1ns/1ps
// Counts the strobes still owed to the current result; a falling-edge
// register shapes each strobe into the second half of its clock.
module ds_strobe_gen #(
    parameter int NUM_DIGITS = 5,
    localparam int REM_W     = $clog2(NUM_DIGITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic fire_pt,
    output logic strobe_n,
    output logic last_fire
);
    logic [REM_W-1:0] remaining;
    logic             stb_cond;
    logic             half_q;

    always_comb begin
        stb_cond  = fire_pt && (remaining != '0);
        last_fire = stb_cond && (remaining == REM_W'(1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        remaining <= '0;
        else if (arm)      remaining <= REM_W'(NUM_DIGITS);
        else if (stb_cond) remaining <= remaining - 1'b1;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= stb_cond;
    end

    assign strobe_n = !(stb_cond && half_q);
endmodule

// File: rtl/digit_scanner.sv
`timescale 1ns/1ps
module digit_scanner #(
    parameter int NUM_DIGITS = 5,
    parameter int BCD_W      = 4,
    parameter int SLOT_CLKS  = 200,
    parameter int STB_AT     = 100
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        eoc,
    input  logic                        ovr,
    input  logic [NUM_DIGITS*BCD_W-1:0] digits,
    input  logic                        ref_start,
    output logic [NUM_DIGITS-1:0]       digit_drv,
    output logic [BCD_W-1:0]            bcd,
    output logic                        strobe_n
);
    import ds_pkg::*;

    localparam int IDX_W = $clog2(NUM_DIGITS);

    scan_state_e      state, state_nx;
    logic [IDX_W-1:0] idx;
    logic             strobe_pt;
    logic             scanning;
    logic             in_blank;
    logic             restart;
    logic             last_fire;
    logic             ovr_q;

    assign scanning = (state == ST_SCAN);
    assign in_blank = (state == ST_BLANK);
    assign restart  = eoc || (in_blank && ref_start);

    always_comb begin
        state_nx = state;
        if (eoc) begin
            state_nx = ST_SCAN;
        end else begin
            unique case (state)
                ST_IDLE:  state_nx = ST_IDLE;
                ST_SCAN:  if (last_fire && ovr_q) state_nx = ST_BLANK;
                ST_BLANK: if (ref_start) state_nx = ST_SCAN;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        for (int i = 0; i < NUM_DIGITS; i++) begin
            digit_drv[i] = scanning && (idx == IDX_W'(i));
        end
    end

    ds_slot_timer #(
        .NUM_DIGITS(NUM_DIGITS),
        .SLOT_CLKS (SLOT_CLKS),
        .STB_AT    (STB_AT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .run      (scanning),
        .idx      (idx),
        .strobe_pt(strobe_pt)
    );

    ds_result_hold #(
        .NUM_DIGITS(NUM_DIGITS),
        .BCD_W     (BCD_W)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (eoc),
        .din     (digits),
        .ovr_in  (ovr),
        .idx     (idx),
        .drive_on(scanning),
        .bcd     (bcd),
        .ovr_q   (ovr_q)
    );

    ds_strobe_gen #(
        .NUM_DIGITS(NUM_DIGITS)
    ) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (eoc),
        .fire_pt  (scanning && strobe_pt),
        .strobe_n (strobe_n),
        .last_fire(last_fire)
    );
endmodule

// File: rtl/ds_checker.sv
`timescale 1ns/1ps
module ds_checker #(
    parameter int NUM_DIGITS = 5,
    parameter int BCD_W      = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  eoc,
    input logic                  ref_start,
    input logic [NUM_DIGITS-1:0] digit_drv,
    input logic [BCD_W-1:0]      bcd,
    input logic                  strobe_n,
    input logic                  ovr_q,
    input logic                  in_blank
);
    localparam logic [NUM_DIGITS-1:0] DRV_MSD = {1'b1, {(NUM_DIGITS-1){1'b0}}};

    AST_DRV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(digit_drv)); // R2

    AST_SCAN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(eoc) && $past(digit_drv) != '0 && digit_drv != '0 && digit_drv != $past(digit_drv))
        |-> (digit_drv == ($past(digit_drv) >> 1) ||
             ($past(digit_drv) == NUM_DIGITS'(1) && digit_drv == DRV_MSD))); // R2

    AST_EOC_TO_MSD: assert property (@(posedge clk) disable iff (!rst_n)
        eoc |=> digit_drv == DRV_MSD); // R9

    AST_OVR_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |-> bcd == '0); // R7

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        digit_drv == '0 |-> bcd == '0); // R1

    AST_STB_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n |-> digit_drv != '0); // R5

    AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_blank && !eoc && !ref_start) |=> (digit_drv == '0 && in_blank)); // R8
endmodule

bind digit_scanner ds_checker #(
    .NUM_DIGITS(NUM_DIGITS),
    .BCD_W     (BCD_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .eoc      (eoc),
    .ref_start(ref_start),
    .digit_drv(digit_drv),
    .bcd      (bcd),
    .strobe_n (strobe_n),
    .ovr_q    (ovr_q),
    .in_blank (in_blank)
);

// File: tb/digit_scanner_tb.sv
`timescale 1ns/1ps
module digit_scanner_tb;
    localparam int SCAN_LEN  = 1001;
    localparam int MSD_LEN   = 201;
    localparam int SLOT      = 200;
    localparam int BLANK_AT  = 902;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eoc = 1'b0;
    logic        ovr = 1'b0;
    logic [19:0] digits = '0;
    logic        ref_start = 1'b0;
    logic [4:0]  digit_drv;
    logic [3:0]  bcd;
    logic        strobe_n;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    digit_scanner u_dut (
        .clk(clk), .rst_n(rst_n), .eoc(eoc), .ovr(ovr), .digits(digits),
        .ref_start(ref_start), .digit_drv(digit_drv), .bcd(bcd), .strobe_n(strobe_n)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Expected outputs at position p (cycles after the eoc or resume edge).
    task automatic model(input int p, input logic [19:0] data, input logic ov,
                         input bit stb_on, output logic [4:0] drv,
                         output logic [3:0] bv, output bit stb);
        int q = p % SCAN_LEN;
        int d;
        int off;
        if (q < MSD_LEN) begin d = 4; off = q; end
        else begin d = 3 - (q - MSD_LEN) / SLOT; off = (q - MSD_LEN) % SLOT; end
        stb = stb_on && (p < SCAN_LEN) && (off == ((d == 4) ? 101 : 100));
        if (stb_on && ov && p >= BLANK_AT) begin
            drv = '0; bv = '0; stb = 1'b0;
        end else begin
            drv = 5'(1 << d);
            bv  = ov ? 4'd0 : data[d*4 +: 4];
        end
    endtask

    // Entered 1 ns after a rising edge; leaves 1 ns after a rising edge.
    task automatic check_window(input int n, input logic [19:0] data, input logic ov,
                                input bit stb_on, input int ref_at, input string rq_bus,
                                output int n_stb, output int drv_err,
                                output int d5_len, output int d4_len);
        int bus_err = 0;
        int pos_err = 0;
        logic [4:0] e_drv;
        logic [3:0] e_bcd;
        bit e_stb;
        n_stb = 0; drv_err = 0; d5_len = 0; d4_len = 0;
        for (int p = 0; p < n; p++) begin
            ref_start = (p == ref_at);
            model(p, data, ov, stb_on, e_drv, e_bcd, e_stb);
            #2;
            if (digit_drv !== e_drv) drv_err++;
            if (bcd !== e_bcd) bus_err++;
            if (strobe_n !== 1'b1) pos_err++;
            if (p < SCAN_LEN && digit_drv == 5'b10000) d5_len++;
            if (p < SCAN_LEN && digit_drv == 5'b01000) d4_len++;
            #5;
            if (strobe_n === 1'b0) n_stb++;
            if (strobe_n !== !e_stb) pos_err++;
            @(posedge clk); #1;
        end
        ref_start = 1'b0;
        check(bus_err == 0, rq_bus, "bcd mismatching cycles", bus_err, 0);
        check(pos_err == 0, "R5", "strobe timing mismatches", pos_err, 0);
    endtask

    task automatic issue_eoc(input logic [19:0] data, input logic ov);
        eoc = 1'b1; digits = data; ovr = ov;
        @(posedge clk); #1;
        eoc = 1'b0; digits = '0; ovr = 1'b0;
    endtask

    task automatic t_reset();
        int bad = 0;
        for (int i = 0; i < 20; i++) begin
            #2;
            if (digit_drv !== 5'd0 || bcd !== 4'd0 || strobe_n !== 1'b1) bad++;
            #5;
            if (strobe_n !== 1'b1) bad++;
            @(posedge clk); #1;
        end
        check(bad == 0, "R1", "idle outputs not quiet", bad, 0);
    endtask

    task automatic t_normal();
        int ns, de, l5, l4;
        issue_eoc(20'h9_7_4_2_5, 1'b0);
        check_window(2200, 20'h9_7_4_2_5, 1'b0, 1'b1, 650, "R4", ns, de, l5, l4);
        check(de == 0, "R2", "drive order mismatches", de, 0);
        check(de == 0, "R10", "drive changed after ref_start in scan", de, 0);
        check(l5 == 201, "R3", "MSD slot length", l5, 201);
        check(l4 == 200, "R3", "D4 slot length", l4, 200);
        check(ns == 5, "R6", "strobes per result", ns, 5);
    endtask

    task automatic t_restart();
        int ns, de, l5, l4;
        issue_eoc(20'h1_2_3_4_5, 1'b0);
        check_window(450, 20'h1_2_3_4_5, 1'b0, 1'b1, -1, "R4", ns, de, l5, l4);
        check(ns == 2, "R9", "strobes before restart", ns, 2);
        issue_eoc(20'h8_6_0_3_9, 1'b0);
        check_window(1100, 20'h8_6_0_3_9, 1'b0, 1'b1, -1, "R9", ns, de, l5, l4);
        check(de == 0, "R9", "drive after mid-scan restart", de, 0);
        check(ns == 5, "R9", "strobes after restart", ns, 5);
    endtask

    task automatic t_overrange();
        int ns, de, l5, l4;
        issue_eoc(20'h9_9_9_9_9, 1'b1);
        check_window(1500, 20'h9_9_9_9_9, 1'b1, 1'b1, -1, "R7", ns, de, l5, l4);
        check(ns == 5, "R6", "strobes in overrange", ns, 5);
        check(de == 0, "R8", "blanking from fifth strobe", de, 0);
        check(digit_drv == 5'd0, "R8", "drives still blank", int'(digit_drv), 0);
        ref_start = 1'b1;
        @(posedge clk); #1;
        ref_start = 1'b0;
        check_window(1100, 20'h9_9_9_9_9, 1'b1, 1'b0, -1, "R7", ns, de, l5, l4);
        check(de == 0, "R8", "scan resumed at MSD after ref_start", de, 0);
        check(ns == 0, "R8", "strobes after resume", ns, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_normal();
        t_restart();
        t_overrange();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule